// File: doc/BRIEF.md
# Symbol Path Test Multiplexer

This block sits between the copper-side and fiber-side symbol datapaths of a two-media converter and decides where each 5-bit code group goes. In normal use it cross-forwards traffic. Symbols received on the fiber side are sent out on the copper transmitter, and symbols received on the copper side are sent out on the fiber transmitter. A 5-bit external symbol port, with one transmit input and one receive output, can replace either side's transmitter source or take either side's receive stream. A two-bit mode value selects which one. Per-side digital loopback and a bypass of the copper-side scrambling complete the test features.

All paths run in one clock domain. Each side's symbol clock is represented by single-cycle strobes: one for the transmit slot and one for the receive slot. The external scrambler and descrambler are outside this block and supply a 5-bit key for every copper symbol. Two select outputs report which side would clock the external port's transmit and receive halves. The mode, the loopback controls and the bypass control are captured while reset is held and are then frozen.

Top module: `sym_path_mux`

## Requirements
- R1: With mode 2'b00, the last fiber receive symbol is sent to the copper transmitter and the last copper receive symbol is sent to the fiber transmitter. The external receive output stays at 5'b00000.
- R2: With mode 2'b10, the copper transmitter takes its symbols from the external transmit input, and the external receive output carries copper receive symbols. Both clock selects read 0 (copper). The fiber transmitter keeps forwarding copper receive symbols.
- R3: With mode 2'b01, the fiber transmitter takes its symbols from the external transmit input, and the external receive output carries fiber receive symbols. Both clock selects read 1 (fiber). The copper transmitter keeps forwarding fiber receive symbols.
- R4: With mode 2'b11, the copper transmitter takes its symbols from the external transmit input, and the external receive output carries fiber receive symbols only. The transmit clock select reads 0 and the receive clock select reads 1.
- R5: A transmitter output changes only at a clock edge where that side's transmit strobe is high. At that edge it takes the source value present, and it holds that value at all other edges.
- R6: The external receive output updates one clock after the edge at which the selected side's receive register is loaded. That edge is the side's receive strobe, or its transmit strobe when that side is in loopback.
- R7: With a side's loopback control at 1, that side's receive path loads that side's unscrambled transmit symbol at its transmit strobe. Its external receive input and receive strobe are ignored. This holds in every mode.
- R8: With the bypass control at 0, the copper output is the transmit symbol XOR the transmit key, and the copper receive symbol is XORed with the receive key before use. With bypass at 1, no XOR is applied.
- R9: The mode, loopback and bypass inputs are captured on every clock edge while reset is low. Changes to them after reset is released have no effect.
- R10: After reset, both transmitter outputs and the external receive output are 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all paths |
| rstN | input | 1 | Synchronous reset, active low; configuration is captured while low |
| modeSel | input | 2 | Path mode, captured in reset |
| loopCuIn | input | 1 | Copper-side digital loopback, captured in reset |
| loopFiIn | input | 1 | Fiber-side digital loopback, captured in reset |
| bypassIn | input | 1 | Copper scrambling bypass, captured in reset |
| cuTxStb | input | 1 | Copper transmit symbol slot |
| fiTxStb | input | 1 | Fiber transmit symbol slot |
| cuRxStb | input | 1 | Copper receive symbol valid |
| fiRxStb | input | 1 | Fiber receive symbol valid |
| portTxd | input | SymW | External port transmit symbol |
| cuRxSym | input | SymW | Copper receive symbol (scrambled) |
| fiRxSym | input | SymW | Fiber receive symbol |
| cuTxKey | input | SymW | Scrambler key for the current copper transmit symbol |
| cuRxKey | input | SymW | Descrambler key for the current copper receive symbol |
| cuTxSym | output | SymW | Copper transmitter symbol |
| fiTxSym | output | SymW | Fiber transmitter symbol |
| portRxd | output | SymW | External port receive symbol |
| txClkSel | output | 1 | Port transmit clock source: 0 copper, 1 fiber |
| rxClkSel | output | 1 | Port receive clock source: 0 copper, 1 fiber |

## Verification
The bench goes after mode 2'b11, where the two halves of the external port point at different sides. A design that decoded only one mode bit would send copper receive symbols to the port or select the wrong clock source there. It times the external receive output against the strobe that fed it, so an output that was combinational, or delayed by two clocks, shows up as a value one step early or late. Loopback is run with the external receive input carrying conflicting data. Loopback is also run with scrambling on, so that looping the scrambled symbol, or letting the mode table win, returns the wrong code. Finally, the configuration pins are changed right after reset is released, which catches a design that keeps tracking them.

// File: rtl/sympath_pkg.sv
package sympath_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_FI_PORT = 2'b01,
    MODE_CU_PORT = 2'b10,
    MODE_MIXED   = 2'b11
  } pathMode_e;

  // strobes and selects handed from control to datapath
  typedef struct packed {
    logic cuTxLd;
    logic fiTxLd;
    logic cuRxLd;
    logic fiRxLd;
    logic cuRxLoop;
    logic fiRxLoop;
    logic cuTxFromPort;
    logic fiTxFromPort;
    logic scrOn;
    logic portLd;
    logic portFromFi;
  } pathCtl_t;

endpackage

// File: rtl/sympath_ctl.sv
module sympath_ctl
  import sympath_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] modeSel,
  input  logic      loopCuIn,
  input  logic      loopFiIn,
  input  logic      bypassIn,
  input  logic      cuTxStb,
  input  logic      fiTxStb,
  input  logic      cuRxStb,
  input  logic      fiRxStb,
  output pathCtl_t  ctl,
  output pathMode_e cfgMode,
  output logic      txClkSel,
  output logic      rxClkSel
);

  logic loopCu, loopFi, bypass;
  logic cuRxEvt, fiRxEvt;
  logic portSelFi, portActive;
  logic portLdDly;

  // configuration follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode <= pathMode_e'(modeSel);
      loopCu  <= loopCuIn;
      loopFi  <= loopFiIn;
      bypass  <= bypassIn;
    end
  end

  // receive events: loopback makes the transmit slot feed the receive register
  assign cuRxEvt = loopCu ? cuTxStb : cuRxStb;
  assign fiRxEvt = loopFi ? fiTxStb : fiRxStb;

  always_comb begin
    portSelFi  = 1'b0;
    portActive = 1'b1;
    txClkSel   = 1'b0;
    rxClkSel   = 1'b0;
    unique case (cfgMode)
      MODE_NORMAL:  portActive = 1'b0;
      MODE_CU_PORT: portSelFi  = 1'b0;
      MODE_FI_PORT: begin
        portSelFi = 1'b1;
        txClkSel  = 1'b1;
        rxClkSel  = 1'b1;
      end
      MODE_MIXED: begin
        portSelFi = 1'b1;
        rxClkSel  = 1'b1;
      end
      default: portActive = 1'b0;
    endcase
  end

  // models the falling-edge update: output follows the receive load by one clock
  always_ff @(posedge clk) begin
    if (!rstN) portLdDly <= 1'b0;
    else       portLdDly <= portActive && (portSelFi ? fiRxEvt : cuRxEvt);
  end

  always_comb begin
    ctl.cuTxLd       = cuTxStb;
    ctl.fiTxLd       = fiTxStb;
    ctl.cuRxLd       = cuRxEvt;
    ctl.fiRxLd       = fiRxEvt;
    ctl.cuRxLoop     = loopCu;
    ctl.fiRxLoop     = loopFi;
    ctl.cuTxFromPort = (cfgMode == MODE_CU_PORT) || (cfgMode == MODE_MIXED);
    ctl.fiTxFromPort = (cfgMode == MODE_FI_PORT);
    ctl.scrOn        = !bypass;
    ctl.portLd       = portLdDly;
    ctl.portFromFi   = portSelFi;
  end

endmodule

// File: rtl/sympath_dp.sv
module sympath_dp
  import sympath_pkg::*;
#(
  parameter int SymW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  pathCtl_t        ctl,
  input  logic [SymW-1:0] portTxd,
  input  logic [SymW-1:0] cuRxSym,
  input  logic [SymW-1:0] fiRxSym,
  input  logic [SymW-1:0] cuTxKey,
  input  logic [SymW-1:0] cuRxKey,
  output logic [SymW-1:0] cuTxSym,
  output logic [SymW-1:0] fiTxSym,
  output logic [SymW-1:0] portRxd
);

  localparam logic [SymW-1:0] Zero = '0;

  logic [SymW-1:0] cuRxReg, fiRxReg;
  logic [SymW-1:0] cuTxSrc, fiTxSrc;
  logic [SymW-1:0] txMask, rxMask, cuRxPlain;

  assign cuTxSrc   = ctl.cuTxFromPort ? portTxd : fiRxReg;
  assign fiTxSrc   = ctl.fiTxFromPort ? portTxd : cuRxReg;
  assign txMask    = ctl.scrOn ? cuTxKey : Zero;
  assign rxMask    = ctl.scrOn ? cuRxKey : Zero;
  assign cuRxPlain = cuRxSym ^ rxMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cuTxSym <= Zero;
      fiTxSym <= Zero;
      cuRxReg <= Zero;
      fiRxReg <= Zero;
      portRxd <= Zero;
    end else begin
      if (ctl.cuTxLd) cuTxSym <= cuTxSrc ^ txMask;
      if (ctl.fiTxLd) fiTxSym <= fiTxSrc;
      if (ctl.cuRxLd) cuRxReg <= ctl.cuRxLoop ? cuTxSrc : cuRxPlain;
      if (ctl.fiRxLd) fiRxReg <= ctl.fiRxLoop ? fiTxSrc : fiRxSym;
      if (ctl.portLd) portRxd <= ctl.portFromFi ? fiRxReg : cuRxReg;
    end
  end

endmodule

// File: rtl/sym_path_mux.sv
module sym_path_mux
  import sympath_pkg::*;
#(
  parameter int SymW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      modeSel,
  input  logic            loopCuIn,
  input  logic            loopFiIn,
  input  logic            bypassIn,
  input  logic            cuTxStb,
  input  logic            fiTxStb,
  input  logic            cuRxStb,
  input  logic            fiRxStb,
  input  logic [SymW-1:0] portTxd,
  input  logic [SymW-1:0] cuRxSym,
  input  logic [SymW-1:0] fiRxSym,
  input  logic [SymW-1:0] cuTxKey,
  input  logic [SymW-1:0] cuRxKey,
  output logic [SymW-1:0] cuTxSym,
  output logic [SymW-1:0] fiTxSym,
  output logic [SymW-1:0] portRxd,
  output logic            txClkSel,
  output logic            rxClkSel
);

  pathCtl_t  ctl;
  pathMode_e cfgMode;

  sympath_ctl u_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .loopCuIn(loopCuIn), .loopFiIn(loopFiIn), .bypassIn(bypassIn),
    .cuTxStb(cuTxStb), .fiTxStb(fiTxStb), .cuRxStb(cuRxStb), .fiRxStb(fiRxStb),
    .ctl(ctl), .cfgMode(cfgMode), .txClkSel(txClkSel), .rxClkSel(rxClkSel)
  );

  sympath_dp #(.SymW(SymW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .portTxd(portTxd), .cuRxSym(cuRxSym), .fiRxSym(fiRxSym),
    .cuTxKey(cuTxKey), .cuRxKey(cuRxKey),
    .cuTxSym(cuTxSym), .fiTxSym(fiTxSym), .portRxd(portRxd)
  );

endmodule

// File: rtl/sym_path_mux_chk.sv
module sym_path_mux_chk
  import sympath_pkg::*;
#(
  parameter int SymW = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            cuTxStb,
  input logic            fiTxStb,
  input logic [SymW-1:0] cuTxSym,
  input logic [SymW-1:0] fiTxSym,
  input logic [SymW-1:0] portRxd,
  input logic            txClkSel,
  input logic            rxClkSel,
  input pathMode_e       cfgMode,
  input logic            portLd
);

  AST_CUTX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cuTxStb |=> $stable(cuTxSym)); // R5
  AST_FITX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fiTxStb |=> $stable(fiTxSym)); // R5
  AST_RXD_IDLE_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode == MODE_NORMAL |-> portRxd == '0); // R1
  AST_RXD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !portLd |=> $stable(portRxd)); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(cfgMode)); // R9
  AST_CLKSEL_FIBER: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode == MODE_FI_PORT |-> (txClkSel && rxClkSel)); // R3
  AST_CLKSEL_MIXED: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode == MODE_MIXED |-> (!txClkSel && rxClkSel)); // R4

endmodule

bind sym_path_mux sym_path_mux_chk #(.SymW(SymW)) u_chk (
  .clk(clk), .rstN(rstN), .cuTxStb(cuTxStb), .fiTxStb(fiTxStb),
  .cuTxSym(cuTxSym), .fiTxSym(fiTxSym), .portRxd(portRxd),
  .txClkSel(txClkSel), .rxClkSel(rxClkSel),
  .cfgMode(cfgMode), .portLd(ctl.portLd)
);

// File: tb/sim_sym_path_mux.sv
module sim_sym_path_mux;

  localparam int SymW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic loopCuIn = 1'b0, loopFiIn = 1'b0, bypassIn = 1'b1;
  logic cuTxStb = 1'b0, fiTxStb = 1'b0, cuRxStb = 1'b0, fiRxStb = 1'b0;
  logic [SymW-1:0] portTxd = '0, cuRxSym = '0, fiRxSym = '0, cuTxKey = '0, cuRxKey = '0;
  logic [SymW-1:0] cuTxSym, fiTxSym, portRxd;
  logic txClkSel, rxClkSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sym_path_mux #(.SymW(SymW)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .loopCuIn(loopCuIn), .loopFiIn(loopFiIn), .bypassIn(bypassIn),
    .cuTxStb(cuTxStb), .fiTxStb(fiTxStb), .cuRxStb(cuRxStb), .fiRxStb(fiRxStb),
    .portTxd(portTxd), .cuRxSym(cuRxSym), .fiRxSym(fiRxSym),
    .cuTxKey(cuTxKey), .cuRxKey(cuRxKey),
    .cuTxSym(cuTxSym), .fiTxSym(fiTxSym), .portRxd(portRxd),
    .txClkSel(txClkSel), .rxClkSel(rxClkSel)
  );

  // scoreboard item: which output (0 copper tx, 1 fiber tx, 2 port rx, 3 clock selects)
  typedef struct {
    string       req;
    int          sel;
    logic [4:0]  exp;
  } item_t;

  item_t sbq[$];
  event  sampleEvt;

  task automatic expect_out(string req, int sel, logic [4:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic sample();
    -> sampleEvt;
    #1;
  endtask

  // monitor: pops expectations and compares with the live outputs
  initial begin
    forever begin
      @(sampleEvt);
      while (sbq.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it = sbq.pop_front();
        case (it.sel)
          0: act = cuTxSym;
          1: act = fiTxSym;
          2: act = portRxd;
          default: act = {3'b000, txClkSel, rxClkSel};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: output %0d actual %h expected %h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cuTxStb = 1'b0; fiTxStb = 1'b0; cuRxStb = 1'b0; fiRxStb = 1'b0;
  endtask

  // hold reset with the given configuration, release, then scramble the pins
  task automatic do_reset(logic [1:0] m, logic lc, logic lf, logic byp);
    @(negedge clk);
    rstN = 1'b0;
    modeSel = m; loopCuIn = lc; loopFiIn = lf; bypassIn = byp;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    modeSel = ~m; loopCuIn = ~lc; loopFiIn = ~lf; bypassIn = ~byp;
    tick();
  endtask

  initial begin
    // R10 reset state, mode 00 with bypass
    do_reset(2'b00, 1'b0, 1'b0, 1'b1);
    expect_out("R10", 0, 5'h00);
    expect_out("R10", 1, 5'h00);
    expect_out("R10", 2, 5'h00);
    expect_out("R1", 3, 5'h00);
    sample();

    // R1 cross forwarding
    fiRxSym = 5'h15; fiRxStb = 1'b1; tick();
    cuTxStb = 1'b1; tick();
    expect_out("R1", 0, 5'h15);
    cuRxSym = 5'h0A; cuRxStb = 1'b1; tick();
    fiTxStb = 1'b1; tick();
    expect_out("R1", 1, 5'h0A);
    expect_out("R1", 2, 5'h00);
    sample();
    // R5 no transmit strobe: copper output holds
    fiRxSym = 5'h07; fiRxStb = 1'b1; tick();
    tick();
    expect_out("R5", 0, 5'h15);
    sample();

    // R8/R9 scrambling on (bypass pin flipped after reset must not matter)
    do_reset(2'b00, 1'b0, 1'b0, 1'b0);
    cuTxKey = 5'h1F; cuRxKey = 5'h05;
    fiRxSym = 5'h03; fiRxStb = 1'b1; tick();
    cuTxStb = 1'b1; tick();
    expect_out("R8", 0, 5'h1C);
    cuRxSym = 5'h11; cuRxStb = 1'b1; tick();
    fiTxStb = 1'b1; tick();
    expect_out("R8", 1, 5'h14);
    expect_out("R9", 3, 5'h00);
    sample();
    cuTxKey = 5'h00; cuRxKey = 5'h00;

    // R2 copper port mode
    do_reset(2'b10, 1'b0, 1'b0, 1'b1);
    expect_out("R2", 3, 5'h00);
    portTxd = 5'h09; cuTxStb = 1'b1; tick();
    expect_out("R2", 0, 5'h09);
    sample();
    cuRxSym = 5'h0C; cuRxStb = 1'b1; tick();
    expect_out("R6", 2, 5'h00);
    sample();
    tick();
    expect_out("R6", 2, 5'h0C);
    sample();
    fiTxStb = 1'b1; tick();
    expect_out("R2", 1, 5'h0C);
    sample();

    // R3 fiber port mode
    do_reset(2'b01, 1'b0, 1'b0, 1'b1);
    expect_out("R3", 3, 5'h03);
    portTxd = 5'h12; fiTxStb = 1'b1; tick();
    expect_out("R3", 1, 5'h12);
    fiRxSym = 5'h1A; fiRxStb = 1'b1; tick();
    tick();
    expect_out("R3", 2, 5'h1A);
    cuTxStb = 1'b1; tick();
    expect_out("R3", 0, 5'h1A);
    sample();

    // R4 mixed mode
    do_reset(2'b11, 1'b0, 1'b0, 1'b1);
    expect_out("R4", 3, 5'h01);
    portTxd = 5'h06; cuTxStb = 1'b1; tick();
    expect_out("R4", 0, 5'h06);
    fiRxSym = 5'h0F; fiRxStb = 1'b1; tick();
    tick();
    expect_out("R4", 2, 5'h0F);
    sample();
    cuRxSym = 5'h01; cuRxStb = 1'b1; tick();
    tick();
    expect_out("R4", 2, 5'h0F);
    sample();

    // R7 copper loopback in copper port mode
    do_reset(2'b10, 1'b1, 1'b0, 1'b1);
    portTxd = 5'h1D; cuTxStb = 1'b1; tick();
    expect_out("R7", 0, 5'h1D);
    tick();
    expect_out("R7", 2, 5'h1D);
    sample();
    cuRxSym = 5'h02; cuRxStb = 1'b1; tick();
    tick();
    expect_out("R7", 2, 5'h1D);
    fiTxStb = 1'b1; tick();
    expect_out("R7", 1, 5'h1D);
    sample();

    // R7 fiber loopback in fiber port mode
    do_reset(2'b01, 1'b0, 1'b1, 1'b1);
    portTxd = 5'h0B; fiTxStb = 1'b1; tick();
    tick();
    expect_out("R7", 2, 5'h0B);
    sample();
    fiRxSym = 5'h04; fiRxStb = 1'b1; tick();
    tick();
    expect_out("R7", 2, 5'h0B);
    sample();

    // R7/R8 loopback returns the unscrambled symbol
    do_reset(2'b10, 1'b1, 1'b0, 1'b0);
    cuTxKey = 5'h0F;
    portTxd = 5'h03; cuTxStb = 1'b1; tick();
    expect_out("R8", 0, 5'h0C);
    tick();
    expect_out("R7", 2, 5'h03);
    sample();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule